// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external interrupt pins into interrupt request lines for a processor core. Two of the pins are sampled on the system clock. Each of them has a two-bit sense code that selects low level, any change, falling edge or rising edge. The third pin catches edges without the system clock, through a capture flop clocked by the pin itself. A one-bit polarity selects which edge it catches. Edge events set a per-pin flag. The flag stays set until software writes a one to it, or until the core acknowledges that pin. Each request is gated by a per-pin mask and by a global enable.

Software reaches the block through a small register port with four word addresses. Address 0 holds the sense codes and address 1 holds the masks. Address 2 holds the flags, which are cleared by writing a one. Address 3 holds control, with the polarity of the third pin at bit 6.

Each synchronous pin has a two-state flag machine. `FLG_IDLE` moves to `FLG_HELD` on a detected edge event. `FLG_HELD` moves back to `FLG_IDLE` on a clear that does not coincide with a new event.

The asynchronous pin has a three-state machine:
- `AS_ARMED` moves to `AS_PENDING` when the synchronized capture reads one.
- `AS_PENDING` moves to `AS_REARM` on a clear write or an acknowledge.
- `AS_REARM` holds the capture flop in reset. It returns to `AS_ARMED` once the synchronized capture reads zero.

Top module: `exti_ctrl`

## Requirements
- R1: With sense code 00, a synchronous pin requests while its synchronized level is low and stops requesting when it returns high. The request is not latched, and this mode never sets the pin's flag.
- R2: With sense code 01, any change of a synchronous pin sets its flag within 3 clock cycles.
- R3: With sense code 10, only a falling edge of a synchronous pin sets its flag. A rising edge leaves it clear.
- R4: With sense code 11, only a rising edge sets the flag. A pulse held for two or more clock cycles is always caught.
- R5: `irq[i]` is the pin's request ANDed with mask bit i (address 1, bits 2:0) and with `gie`. Flags still set while a pin is masked, so `irq` rises as soon as the mask bit is set.
- R6: Writing address 2 clears each flag (bit i is pin i) whose write-data bit is one. Bits written as zero leave their flags unchanged.
- R7: For the asynchronous pin (flag bit 2), polarity bit 6 of address 3 set to 0 selects falling edges and set to 1 selects rising edges. The opposite edge does not set the flag.
- R8: Changing the polarity can itself set the flag of the asynchronous pin. This happens when the bit goes from 1 to 0 with the pin low, or from 0 to 1 with the pin high.
- R9: A one-cycle `ack_valid` with `ack_id` equal to i clears flag i of an edge-mode pin.
- R10: After reset, all registers read 0 and `irq` is 0.
- R11: Address 0 reads the sense codes, with pin 0 in bits 1:0 and pin 1 in bits 3:2. Address 1 reads the masks in bits 2:0 and address 3 reads the polarity in bit 6. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xin | input | 2 | Synchronously sampled interrupt pins |
| xin_async | input | 1 | Interrupt pin with clockless edge capture |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_id | input | 2 | Index of the acknowledged pin |
| irq | output | 3 | Gated interrupt requests |

## Verification
Random trials draw the sense code, the old and new pin levels, the mask and `gie`. They compare the flag and `irq` against an edge function in the bench. A design that swapped the edge encodings, or latched the level mode, would show a wrong flag in those trials. Directed cases cover the following:
- A flag set while masked, which a design without early flagging would never raise.
- A write of zeros to the flag register, which a plain overwrite would clear.
- Both false-trigger directions of a polarity change.
- Re-arming of the clockless capture after a clear, which a design that never reset the capture flop would miss on the next edge.

// File: rtl/exti_pkg.sv
package exti_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        FLG_IDLE,
        FLG_HELD
    } flg_e;

    typedef enum logic [1:0] {
        AS_ARMED   = 2'b00,
        AS_PENDING = 2'b01,
        AS_REARM   = 2'b10
    } as_e;

    localparam int unsigned ADDR_SENSE = 0;
    localparam int unsigned ADDR_MASK  = 1;
    localparam int unsigned ADDR_FLAG  = 2;
    localparam int unsigned ADDR_CTRL  = 3;
endpackage

// File: rtl/exti_sync_det.sv
module exti_sync_det
    import exti_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin,
    input  sense_e mode,
    input  logic   clr,
    output logic   req,
    output logic   flag
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              smp;
    logic              hit;
    flg_e              st_q, st_d;

    assign smp = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= smp;
        end
    end

    always_comb begin
        unique case (mode)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = smp ^ prev_q;
            SENSE_FALL: hit = prev_q & ~smp;
            SENSE_RISE: hit = ~prev_q & smp;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: if (hit)         st_d = FLG_HELD;
            FLG_HELD: if (clr && !hit) st_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (st_q == FLG_HELD);
        req  = (mode == SENSE_LOW) ? ~smp : flag;
    end

    // R1
    lvl_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(mode) != SENSE_LOW);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !hit) |=> !flag);
endmodule

// File: rtl/exti_async_det.sv
module exti_async_det
    import exti_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic clr,
    output logic flag
);
    logic              edge_ck;
    logic              cap_clr;
    logic              cap_q;
    logic [STAGES-1:0] csync_q;
    logic              cs;
    as_e               st_q, st_d;

    // pol=1: rising pin edge clocks the capture; pol=0: falling edge
    assign edge_ck = ~(pin ^ pol);
    assign cap_clr = ~rst_n | (st_q == AS_REARM);
    assign cs      = csync_q[STAGES-1];

    always_ff @(posedge edge_ck or posedge cap_clr) begin
        if (cap_clr) cap_q <= 1'b0;
        else         cap_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csync_q <= '0;
        else        csync_q <= {csync_q[STAGES-2:0], cap_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AS_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AS_ARMED:   if (cs)  st_d = AS_PENDING;
            AS_PENDING: if (clr) st_d = AS_REARM;
            AS_REARM:   if (!cs) st_d = AS_ARMED;
            default:             st_d = AS_ARMED;
        endcase
    end

    always_comb begin
        flag = (st_q == AS_PENDING);
    end

    // R6
    async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R7
    async_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cs));
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int N_SYNC  = 2,
    parameter int STAGES  = 2,
    parameter int DW      = 8,
    parameter int AW      = 2,
    parameter int POL_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SYNC-1:0] xin,
    input  logic              xin_async,
    input  logic              gie,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              ack_valid,
    input  logic [AW-1:0]     ack_id,
    output logic [N_SYNC:0]   irq
);
    localparam int N_PIN = N_SYNC + 1;

    logic [2*N_SYNC-1:0] sense_q;
    logic [N_PIN-1:0]    mask_q;
    logic                pol_q;
    logic [N_PIN-1:0]    clr_v;
    logic [N_PIN-1:0]    flag_v;
    logic [N_PIN-1:0]    req_v;
    logic                unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
            pol_q   <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADDR_SENSE)) sense_q <= reg_wdata[2*N_SYNC-1:0];
            if (reg_addr == AW'(ADDR_MASK))  mask_q  <= reg_wdata[N_PIN-1:0];
            if (reg_addr == AW'(ADDR_CTRL))  pol_q   <= reg_wdata[POL_BIT];
        end
    end

    generate
        for (genvar i = 0; i < N_PIN; i++) begin : g_clr
            assign clr_v[i] = (reg_wr && reg_addr == AW'(ADDR_FLAG) && reg_wdata[i])
                            || (ack_valid && ack_id == AW'(i));
        end
        for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
            exti_sync_det #(.STAGES(STAGES)) u_det (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (xin[i]),
                .mode (sense_e'(sense_q[2*i +: 2])),
                .clr  (clr_v[i]),
                .req  (req_v[i]),
                .flag (flag_v[i])
            );
        end
    endgenerate

    exti_async_det #(.STAGES(STAGES)) u_async (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (xin_async),
        .pol  (pol_q),
        .clr  (clr_v[N_SYNC]),
        .flag (flag_v[N_SYNC])
    );
    assign req_v[N_SYNC] = flag_v[N_SYNC];

    always_comb begin
        irq = req_v & mask_q & {N_PIN{gie}};
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(ADDR_SENSE): reg_rdata[2*N_SYNC-1:0] = sense_q;
            AW'(ADDR_MASK):  reg_rdata[N_PIN-1:0]    = mask_q;
            AW'(ADDR_FLAG):  reg_rdata[N_PIN-1:0]    = flag_v;
            default:         reg_rdata[POL_BIT]      = pol_q;
        endcase
    end

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> gie);

    // R7
    pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pol_q) |-> $past(reg_wr && reg_addr == AW'(ADDR_CTRL)));
endmodule

// File: tb/sim_exti_ctrl.sv
module sim_exti_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] xin = 2'b11;
    logic       xin_async = 1'b1;
    logic       gie = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_id = '0;
    logic [2:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int modes [2];

    always #(CLK_P/2) clk = ~clk;

    exti_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .xin(xin), .xin_async(xin_async), .gie(gie),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_id(ack_id), .irq(irq)
    );

    function automatic bit edge_hit(int m, bit o, bit n);
        case (m)
            1:       return o != n;
            2:       return o & !n;
            3:       return !o & n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_modes();
        wr(2'd0, 8'(modes[0] | (modes[1] << 2)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed1234));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R10: reset state
        chk("R10 irq", 8'(irq), 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R10 reg", d, 8'h00);
        end
        // R11: readback layout
        wr(2'd0, 8'hB4); rd(2'd0, d); chk("R11 sense", d, 8'h04);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R11 mask", d, 8'h07);
        wr(2'd3, 8'hFF); rd(2'd3, d); chk("R11 ctrl", d, 8'h40);
        wr(2'd3, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wait_n(6);
        wr(2'd2, 8'h07);
        wait_n(6);

        // R1 R2 R3 R4 R5: random trials on the synchronous pins
        modes[0] = 3; modes[1] = 3;
        for (int t = 0; t < 60; t++) begin
            int  p, m;
            bit  o, n, msk, g, hit;
            p = int'($urandom % 2);
            m = int'($urandom % 4);
            msk = 1'($urandom);
            g   = 1'($urandom);
            n   = 1'($urandom);
            o   = xin[p];
            modes[p] = m;
            set_modes();
            wr(2'd1, 8'(msk) << p);
            gie = g;
            wr(2'd2, 8'h03);
            wait_n(2);
            xin[p] = n;
            wait_n(5);
            hit = edge_hit(m, o, n);
            rd(2'd2, d);
            chk($sformatf("R%0d flag pin%0d mode%0d", m + 1, p, m), 8'(d[p]), 8'(hit));
            chk($sformatf("R%0d R5 irq pin%0d", m + 1, p), 8'(irq[p]),
                8'(((m == 0) ? !n : hit) & msk & g));
        end
        // leave both pins high in rising mode, flags clear
        xin = 2'b11;
        modes[0] = 3; modes[1] = 3; set_modes();
        wait_n(5);
        wr(2'd2, 8'h07); wr(2'd1, 8'h00); gie = 1'b1;
        wait_n(3);

        // R1: level mode not latched
        modes[0] = 0; set_modes(); wr(2'd1, 8'h01);
        xin[0] = 1'b0; wait_n(4);
        chk("R1 level low irq", 8'(irq[0]), 8'h01);
        xin[0] = 1'b1; wait_n(4);
        chk("R1 level released irq", 8'(irq[0]), 8'h00);
        rd(2'd2, d); chk("R1 no flag", 8'(d[0]), 8'h00);

        // R4: two-cycle high pulse in rising mode
        modes[0] = 3; set_modes();
        xin[0] = 1'b0; wait_n(5); wr(2'd2, 8'h01); wait_n(2);
        xin[0] = 1'b1; wait_n(2); xin[0] = 1'b0; wait_n(4);
        rd(2'd2, d); chk("R4 short pulse", 8'(d[0]), 8'h01);
        xin[0] = 1'b1; wait_n(5); wr(2'd2, 8'h01); wait_n(2);

        // R5: flag set while masked, irq on unmask
        modes[1] = 2; set_modes(); wr(2'd1, 8'h00);
        xin[1] = 1'b0; wait_n(5);
        chk("R5 masked irq", 8'(irq[1]), 8'h00);
        wr(2'd1, 8'h02); #1;
        chk("R5 unmask irq", 8'(irq[1]), 8'h01);
        gie = 1'b0; #1;
        chk("R5 gie off", 8'(irq), 8'h00);
        gie = 1'b1;

        // R6: zero write no effect, one write clears
        wr(2'd2, 8'h00); rd(2'd2, d);
        chk("R6 zero write", 8'(d[1]), 8'h01);
        wr(2'd2, 8'h02); wait_n(1); rd(2'd2, d);
        chk("R6 one write", 8'(d[1]), 8'h00);

        // R9: acknowledge clears
        xin[1] = 1'b1; wait_n(2); xin[1] = 1'b0; wait_n(5);
        rd(2'd2, d); chk("R9 set", 8'(d[1]), 8'h01);
        ack_valid = 1'b1; ack_id = 2'd1; wait_n(1); ack_valid = 1'b0;
        rd(2'd2, d); chk("R9 ack clear", 8'(d[1]), 8'h00);
        xin[1] = 1'b1; wait_n(3);

        // R7: async falling with polarity 0
        wr(2'd1, 8'h04);
        xin_async = 1'b0; wait_n(5);
        rd(2'd2, d); chk("R7 falling", 8'(d[2]), 8'h01);
        chk("R7 irq", 8'(irq[2]), 8'h01);
        wr(2'd2, 8'h04); wait_n(6);
        xin_async = 1'b1; wait_n(5);
        rd(2'd2, d); chk("R7 rising ignored", 8'(d[2]), 8'h00);

        // R8: polarity 0->1 with pin high triggers
        wr(2'd3, 8'h40); wait_n(5);
        rd(2'd2, d); chk("R8 pol up pin high", 8'(d[2]), 8'h01);
        wr(2'd2, 8'h04); wait_n(6);
        // R7: rising with polarity 1, repeated
        for (int k = 0; k < 4; k++) begin
            xin_async = 1'b0; wait_n(4);
            rd(2'd2, d); chk("R7 fall ignored pol1", 8'(d[2]), 8'h00);
            xin_async = 1'b1; wait_n(5);
            rd(2'd2, d); chk("R7 rise pol1", 8'(d[2]), 8'h01);
            if (k[0]) begin
                ack_valid = 1'b1; ack_id = 2'd2; wait_n(1); ack_valid = 1'b0;
                rd(2'd2, d); chk("R9 async ack", 8'(d[2]), 8'h00);
            end else begin
                wr(2'd2, 8'h04);
            end
            wait_n(6);
        end
        // R8: polarity 1->0 with pin low triggers
        xin_async = 1'b0; wait_n(5);
        rd(2'd2, d); chk("R8 quiet before", 8'(d[2]), 8'h00);
        wr(2'd3, 8'h00); wait_n(5);
        rd(2'd2, d); chk("R8 pol down pin low", 8'(d[2]), 8'h01);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule